// File: doc/BRIEF.md
# Triple-Copy Voted Memory with Background Scrubber

This block is a single-port synchronous memory that keeps every word in three identical RAM copies. Each copy has its own enable, write-enable, address and write-data lines, and every read passes the three copies' outputs through a bit-by-bit two-out-of-three vote. A copy whose stored bits were flipped by an upset is therefore outvoted as long as the other two copies still agree on each bit.

Voting alone does not stop damage from building up. Flips that land in different copies of the same word over time would eventually defeat the vote. A background scrubber therefore uses every cycle the user leaves free. It reads the next word, compares each copy against the voted value and, only when a copy disagrees, writes the voted value back into all three copies. The scrub pointer walks the whole address range, wraps to zero and counts finished passes.

User reads report a per-copy disagreement map in the same cycle as their data. A fault-injection input lets a test XOR a mask into one copy's word without disturbing the others.

Top module: `tmr_scrub_ram`

## Requirements
- R1: While reset is low and in the first cycle after it, `rd_valid`, `err_flag`, `err_copies` and `err_scrub` are 0, and `scrub_addr` and `scrub_passes` are 0.
- R2: A user write (`req_valid`=1, `req_write`=1) stores `req_wdata` into all three copies at `req_addr`. A user read (`req_valid`=1, `req_write`=0) drives `rd_valid`=1 in the following cycle, with `rd_data` equal to the stored word.
- R3: `rd_data` is the bitwise majority of the three copies. A word stays correct when any bits of one copy differ, and also when different bits differ in two copies.
- R4: A user request on a cycle always owns the memory port. The scrub pointer `scrub_addr` does not move on any cycle with `req_valid`=1.
- R5: In the cycle a read result appears (from a user read or a scrub read), `err_flag` is 1 exactly when some copy differs from the voted word. `err_copies` bit c is 1 when copy c differs, and `err_scrub` is 1 only when that result belongs to a scrub read. All three are 0 in every other cycle.
- R6: On idle cycles the scrubber reads the word at `scrub_addr` and then advances the pointer. It never reads on the cycle right after its own read. The pointer wraps from DEPTH-1 to 0.
- R7: `scrub_passes` increments by one each time the pointer wraps from DEPTH-1 to 0.
- R8: When a scrub read shows a disagreement, the voted word is written into all three copies on the next cycle without a user request. When a scrub read shows no disagreement, nothing is written, so a clean word costs two idle cycles and a repaired word costs three.
- R9: A user write to the address whose repair is waiting, or to the address whose scrub result is being checked in that same cycle, cancels that repair. The user's data remains.
- R10: With `inj_en`=1, the word at `inj_addr` in copy `inj_copy` (0, 1 or 2; the value 3 selects none) is XORed with `inj_mask` on that clock edge, after any write of the same edge. The other copies are untouched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | User access request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | User word address |
| req_wdata | input | DATA_W | User write data |
| rd_valid | output | 1 | User read data valid |
| rd_data | output | DATA_W | Voted read data |
| err_flag | output | 1 | A copy disagreed with the vote on the current read result |
| err_copies | output | 3 | Per-copy disagreement map |
| err_scrub | output | 1 | Current disagreement comes from a scrub read |
| scrub_addr | output | ADDR_W | Next address the scrubber will read |
| scrub_passes | output | PASS_W | Completed scrub passes (wraps) |
| inj_en | input | 1 | Fault-injection strobe (test hook) |
| inj_copy | input | 2 | Copy to corrupt |
| inj_addr | input | ADDR_W | Word to corrupt |
| inj_mask | input | DATA_W | Bits to flip |

## Verification
The assertions check on every cycle the rules that do not depend on stored data. They cover the pointer staying frozen during user cycles and remaining inside the address range, and the pass count moving together with each wrap. They also cover read data arriving one cycle after a user read, and repairs starting only after a scrub read has seen a disagreement. Finally they check that a user write to the pending address cancels the repair, and that an injection touches at most one copy. Only the bench scenarios can show the value-level results. These are the voted word hiding one-copy and split two-copy faults, faults disappearing after a full scrub pass, the two-cycle versus three-cycle scan cadence, and user data surviving a repair that raced with it.

// File: rtl/tmr_ram_pkg.sv
package tmr_ram_pkg;

   localparam int unsigned COPIES = 3;

   typedef enum logic [1:0] {
      OP_IDLE  = 2'd0,
      OP_USER  = 2'd1,
      OP_WBACK = 2'd2,
      OP_SCRUB = 2'd3
   } port_op_e;

   function automatic logic maj3(input logic a, input logic b, input logic c);
      return (a & b) | (a & c) | (b & c);
   endfunction

endpackage

// File: rtl/tmr_ram_copy.sv
module tmr_ram_copy #(
   parameter int unsigned DATA_W = 16,
   parameter int unsigned DEPTH  = 256,
   localparam int unsigned ADDR_W = $clog2(DEPTH)
) (
   input  logic              clk,
   input  logic              en,
   input  logic              we,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata,
   input  logic              flip_en,
   input  logic [ADDR_W-1:0] flip_addr,
   input  logic [DATA_W-1:0] flip_mask
);

   logic [DATA_W-1:0] mem [DEPTH];
   logic [DATA_W-1:0] flip_base;

   // an upset lands after a same-edge write to the same word
   always_comb begin
      if (en && we && (addr == flip_addr)) flip_base = wdata;
      else                                 flip_base = mem[flip_addr];
   end

   always_ff @(posedge clk) begin
      if (en && !we) rdata <= mem[addr];
      if (en && we)  mem[addr] <= wdata;
      if (flip_en)   mem[flip_addr] <= flip_base ^ flip_mask;
   end

endmodule

// File: rtl/tmr_vote.sv
module tmr_vote
   import tmr_ram_pkg::*;
#(
   parameter int unsigned DATA_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              chk_en,
   input  logic [DATA_W-1:0] q0,
   input  logic [DATA_W-1:0] q1,
   input  logic [DATA_W-1:0] q2,
   output logic [DATA_W-1:0] voted,
   output logic [2:0]        diff
);

   for (genvar b = 0; b < DATA_W; b++) begin : g_bit
      assign voted[b] = maj3(q0[b], q1[b], q2[b]);
   end

   assign diff[0] = |(q0 ^ voted);
   assign diff[1] = |(q1 ^ voted);
   assign diff[2] = |(q2 ^ voted);

   // R3: two agreeing copies always decide the word
   p_pair_decides_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (chk_en && ((q0 == q1) || (q0 == q2))) |-> (voted == q0));

   p_one_outvoted_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (chk_en && (q1 == q2)) |-> (voted == q1 && !diff[1] && !diff[2]));

endmodule

// File: rtl/tmr_scrub_ctrl.sv
module tmr_scrub_ctrl
   import tmr_ram_pkg::*;
#(
   parameter int unsigned DATA_W = 16,
   parameter int unsigned DEPTH  = 256,
   parameter int unsigned PASS_W = 16,
   localparam int unsigned ADDR_W = $clog2(DEPTH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              user_req,
   input  logic              user_we,
   input  logic [ADDR_W-1:0] user_addr,
   input  logic              chk_mismatch,
   input  logic [DATA_W-1:0] chk_word,
   output port_op_e          op_o,
   output logic [ADDR_W-1:0] scan_ptr,
   output logic              chk_busy,
   output logic [ADDR_W-1:0] wb_addr,
   output logic [DATA_W-1:0] wb_data,
   output logic [PASS_W-1:0] passes
);

   localparam logic [ADDR_W-1:0] LAST = ADDR_W'(DEPTH - 1);

   logic [ADDR_W-1:0] ptr_q, chk_addr_q, wb_addr_q;
   logic [DATA_W-1:0] wb_data_q;
   logic [PASS_W-1:0] pass_q;
   logic              busy_q, pend_q;
   logic              at_last, user_wr_chk, user_wr_wb;

   // priority: user, pending repair, scrub read (not right after one)
   always_comb begin
      if (user_req)     op_o = OP_USER;
      else if (pend_q)  op_o = OP_WBACK;
      else if (!busy_q) op_o = OP_SCRUB;
      else              op_o = OP_IDLE;
   end

   assign at_last     = (ptr_q == LAST);
   assign user_wr_chk = user_req && user_we && (user_addr == chk_addr_q);
   assign user_wr_wb  = user_req && user_we && (user_addr == wb_addr_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ptr_q      <= '0;
         chk_addr_q <= '0;
         wb_addr_q  <= '0;
         wb_data_q  <= '0;
         pass_q     <= '0;
         busy_q     <= 1'b0;
         pend_q     <= 1'b0;
      end else begin
         busy_q <= (op_o == OP_SCRUB);
         if (op_o == OP_SCRUB) begin
            chk_addr_q <= ptr_q;
            if (at_last) begin
               ptr_q  <= '0;
               pass_q <= pass_q + 1'b1;
            end else begin
               ptr_q <= ptr_q + 1'b1;
            end
         end
         if (busy_q && chk_mismatch && !user_wr_chk) begin
            pend_q    <= 1'b1;
            wb_addr_q <= chk_addr_q;
            wb_data_q <= chk_word;
         end else if (pend_q && ((op_o == OP_WBACK) || user_wr_wb)) begin
            pend_q <= 1'b0;
         end
      end
   end

   assign scan_ptr = ptr_q;
   assign chk_busy = busy_q;
   assign wb_addr  = wb_addr_q;
   assign wb_data  = wb_data_q;
   assign passes   = pass_q;

   p_ptr_frozen_r4: assert property (@(posedge clk) disable iff (!rst_n)
      user_req |=> $stable(ptr_q));

   p_ptr_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
      ptr_q <= LAST);

   p_no_back_to_back_r6: assert property (@(posedge clk) disable iff (!rst_n)
      busy_q |=> !busy_q);

   p_wrap_counts_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (op_o == OP_SCRUB && at_last) |=> (ptr_q == '0 && pass_q == PASS_W'($past(pass_q) + 1'b1)));

   p_repair_needs_mismatch_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pend_q) |-> $past(busy_q && chk_mismatch));

   p_cancel_on_user_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (pend_q && user_wr_wb) |=> !pend_q);

endmodule

// File: rtl/tmr_scrub_ram.sv
module tmr_scrub_ram
   import tmr_ram_pkg::*;
#(
   parameter int unsigned DATA_W    = 16,
   parameter int unsigned DEPTH     = 256,
   parameter int unsigned PASS_W    = 16,
   parameter bit          FLIP_HOOK = 1'b1,
   localparam int unsigned ADDR_W   = $clog2(DEPTH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic              req_write,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_wdata,
   output logic              rd_valid,
   output logic [DATA_W-1:0] rd_data,
   output logic              err_flag,
   output logic [2:0]        err_copies,
   output logic              err_scrub,
   output logic [ADDR_W-1:0] scrub_addr,
   output logic [PASS_W-1:0] scrub_passes,
   input  logic              inj_en,
   input  logic [1:0]        inj_copy,
   input  logic [ADDR_W-1:0] inj_addr,
   input  logic [DATA_W-1:0] inj_mask
);

   if (DEPTH < 2) begin : g_bad_depth
      $error("tmr_scrub_ram: DEPTH must be at least 2");
   end
   if (DATA_W < 1) begin : g_bad_width
      $error("tmr_scrub_ram: DATA_W must be at least 1");
   end
   if (PASS_W < 1) begin : g_bad_pass
      $error("tmr_scrub_ram: PASS_W must be at least 1");
   end

   port_op_e          op;
   logic              port_en, port_we;
   logic [ADDR_W-1:0] port_addr, scan_ptr, wb_addr;
   logic [DATA_W-1:0] port_wdata, wb_data, voted;
   logic              chk_busy, rd_user_q, diff_any, result_live;
   logic [2:0]        diff;

   logic [COPIES-1:0] c_en, c_we, c_flip;
   logic [ADDR_W-1:0] c_addr  [COPIES];
   logic [DATA_W-1:0] c_wdata [COPIES];
   logic [DATA_W-1:0] c_rdata [COPIES];

   tmr_scrub_ctrl #(
      .DATA_W(DATA_W), .DEPTH(DEPTH), .PASS_W(PASS_W)
   ) u_ctrl (
      .clk          (clk),
      .rst_n        (rst_n),
      .user_req     (req_valid),
      .user_we      (req_write),
      .user_addr    (req_addr),
      .chk_mismatch (diff_any),
      .chk_word     (voted),
      .op_o         (op),
      .scan_ptr     (scan_ptr),
      .chk_busy     (chk_busy),
      .wb_addr      (wb_addr),
      .wb_data      (wb_data),
      .passes       (scrub_passes)
   );

   always_comb begin
      port_en    = 1'b1;
      port_we    = 1'b0;
      port_addr  = req_addr;
      port_wdata = req_wdata;
      unique case (op)
         OP_USER:  port_we = req_write;
         OP_WBACK: begin
            port_we    = 1'b1;
            port_addr  = wb_addr;
            port_wdata = wb_data;
         end
         OP_SCRUB: port_addr = scan_ptr;
         default:  port_en = 1'b0;
      endcase
   end

   for (genvar c = 0; c < COPIES; c++) begin : g_copy
      assign c_en[c]    = port_en;
      assign c_we[c]    = port_we;
      assign c_addr[c]  = port_addr;
      assign c_wdata[c] = port_wdata;

      if (FLIP_HOOK) begin : g_hook
         assign c_flip[c] = inj_en && (inj_copy == 2'(c));
      end else begin : g_nohook
         assign c_flip[c] = 1'b0;
      end

      tmr_ram_copy #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_ram (
         .clk       (clk),
         .en        (c_en[c]),
         .we        (c_we[c]),
         .addr      (c_addr[c]),
         .wdata     (c_wdata[c]),
         .rdata     (c_rdata[c]),
         .flip_en   (c_flip[c]),
         .flip_addr (inj_addr),
         .flip_mask (inj_mask)
      );
   end

   tmr_vote #(.DATA_W(DATA_W)) u_vote (
      .clk    (clk),
      .rst_n  (rst_n),
      .chk_en (result_live),
      .q0     (c_rdata[0]),
      .q1     (c_rdata[1]),
      .q2     (c_rdata[2]),
      .voted  (voted),
      .diff   (diff)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) rd_user_q <= 1'b0;
      else        rd_user_q <= (op == OP_USER) && !req_write;
   end

   assign diff_any    = |diff;
   assign result_live = rd_user_q | chk_busy;

   assign rd_valid   = rd_user_q;
   assign rd_data    = voted;
   assign err_flag   = result_live & diff_any;
   assign err_copies = result_live ? diff : 3'b000;
   assign err_scrub  = chk_busy & diff_any;
   assign scrub_addr = scan_ptr;

   p_read_latency_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !req_write) |=> rd_valid);

   p_err_follows_read_r5: assert property (@(posedge clk) disable iff (!rst_n)
      err_flag |-> $past(((op == OP_USER) && !req_write) || (op == OP_SCRUB)));

   p_flip_one_copy_r10: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(c_flip));

endmodule

// File: tb/tb_tmr_scrub_ram.sv
module tb_tmr_scrub_ram;

   localparam int DW    = 16;
   localparam int DEPTH = 256;
   localparam int AW    = 8;
   localparam int PW    = 16;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #4 clk = ~clk;

   logic          req_valid = 0, req_write = 0, inj_en = 0;
   logic [AW-1:0] req_addr = '0, inj_addr = '0;
   logic [DW-1:0] req_wdata = '0, inj_mask = '0;
   logic [1:0]    inj_copy = 2'd3;
   logic          rd_valid, err_flag, err_scrub;
   logic [DW-1:0] rd_data;
   logic [2:0]    err_copies;
   logic [AW-1:0] scrub_addr;
   logic [PW-1:0] scrub_passes;

   tmr_scrub_ram #(.DATA_W(DW), .DEPTH(DEPTH), .PASS_W(PW)) dut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
      .req_addr(req_addr), .req_wdata(req_wdata), .rd_valid(rd_valid),
      .rd_data(rd_data), .err_flag(err_flag), .err_copies(err_copies),
      .err_scrub(err_scrub), .scrub_addr(scrub_addr), .scrub_passes(scrub_passes),
      .inj_en(inj_en), .inj_copy(inj_copy), .inj_addr(inj_addr), .inj_mask(inj_mask)
   );

   int checks = 0;
   int errors = 0;
   bit done = 0;

   task automatic chk(string tag, longint act, longint exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
      end
   endtask

   function automatic logic [DW-1:0] vote3(logic [DW-1:0] a, logic [DW-1:0] b, logic [DW-1:0] c);
      return (a & b) | (a & c) | (b & c);
   endfunction

   function automatic logic [DW-1:0] pat(int a);
      return DW'(a * 40503) ^ 16'h5A5A;
   endfunction

   // behavioural reference
   logic [DW-1:0] cm [3][DEPTH];
   logic [DW-1:0] mq [3];
   int  m_ptr = 0, m_passes = 0, m_chk = 0, m_pend_addr = 0;
   bit  m_pend = 0, m_infl = 0, m_rdu = 0;
   logic [DW-1:0] m_pend_data = '0;

   function automatic bit m_mis();
      logic [DW-1:0] v;
      v = vote3(mq[0], mq[1], mq[2]);
      return (mq[0] != v) || (mq[1] != v) || (mq[2] != v);
   endfunction

   always @(posedge clk) begin : model
      int op, wa;
      logic [DW-1:0] v, wd;
      bit uw;
      if (!rst_n) begin
         m_ptr = 0; m_passes = 0; m_pend = 0; m_infl = 0; m_rdu = 0;
      end else begin
         op = req_valid ? 1 : (m_pend ? 2 : (!m_infl ? 3 : 0));
         uw = req_valid && req_write;
         wa = m_pend_addr;
         wd = m_pend_data;
         v  = vote3(mq[0], mq[1], mq[2]);
         if (m_infl && m_mis() && !(uw && int'(req_addr) == m_chk)) begin
            m_pend = 1; m_pend_addr = m_chk; m_pend_data = v;
         end else if (m_pend && (op == 2 || (uw && int'(req_addr) == m_pend_addr))) begin
            m_pend = 0;
         end
         if (op == 1 && !req_write) for (int c = 0; c < 3; c++) mq[c] = cm[c][req_addr];
         if (op == 3) for (int c = 0; c < 3; c++) mq[c] = cm[c][m_ptr];
         m_rdu  = (op == 1 && !req_write);
         m_infl = (op == 3);
         if (op == 3) m_chk = m_ptr;
         if (op == 1 && req_write) for (int c = 0; c < 3; c++) cm[c][req_addr] = req_wdata;
         if (op == 2) for (int c = 0; c < 3; c++) cm[c][wa] = wd;
         if (inj_en && inj_copy != 2'd3) cm[inj_copy][inj_addr] = cm[inj_copy][inj_addr] ^ inj_mask;
         if (op == 3) begin
            if (m_ptr == DEPTH - 1) begin
               m_ptr = 0;
               m_passes = (m_passes + 1) % (1 << PW);
            end else begin
               m_ptr++;
            end
         end
      end
   end

   // per-cycle comparison
   always @(negedge clk) begin : compare
      bit live, mis;
      logic [DW-1:0] v;
      logic [2:0] dm;
      live = m_rdu || m_infl;
      mis  = m_mis();
      v    = vote3(mq[0], mq[1], mq[2]);
      dm   = {mq[2] != v, mq[1] != v, mq[0] != v};
      if (!rst_n) begin
         chk("R1 rd_valid in reset", rd_valid, 0);
         chk("R1 err_flag in reset", err_flag, 0);
         chk("R1 scrub_addr in reset", scrub_addr, 0);
         chk("R1 scrub_passes in reset", scrub_passes, 0);
      end else begin
         chk("R2 rd_valid", rd_valid, m_rdu);
         if (m_rdu) chk("R3 rd_data voted", rd_data, v);
         chk("R5 err_flag", err_flag, live && mis);
         chk("R5 err_copies", err_copies, live ? dm : 3'b000);
         chk("R5 err_scrub", err_scrub, m_infl && mis);
         chk("R6 scrub_addr", scrub_addr, m_ptr);
         chk("R7 scrub_passes", scrub_passes, m_passes);
      end
   end

   task automatic step(bit v, bit w, int a, logic [DW-1:0] d);
      req_valid = v; req_write = w; req_addr = AW'(a); req_wdata = d;
      inj_en = 0; inj_copy = 2'd3;
      @(posedge clk); #2;
   endtask

   task automatic stepi(bit v, bit w, int a, logic [DW-1:0] d, int c, int ia, logic [DW-1:0] m);
      req_valid = v; req_write = w; req_addr = AW'(a); req_wdata = d;
      inj_en = 1; inj_copy = 2'(c); inj_addr = AW'(ia); inj_mask = m;
      @(posedge clk); #2;
      inj_en = 0; inj_copy = 2'd3;
   endtask

   task automatic rd_check(int a, logic [DW-1:0] exp, bit e_err, logic [2:0] e_map, string tag);
      step(1, 0, a, '0);
      chk({tag, " rd_valid"}, rd_valid, 1);
      chk({tag, " rd_data"}, rd_data, exp);
      chk({tag, " err_flag"}, err_flag, e_err);
      chk({tag, " err_copies"}, err_copies, e_map);
      chk({tag, " err_scrub on user read (R5)"}, err_scrub, 0);
   endtask

   task automatic idle_until_ptr(int target);
      for (int i = 0; i < 2000 && m_ptr != target; i++) step(0, 0, 0, '0);
   endtask

   initial begin : stim
      int p0;
      bit saw_wrap;
      logic [AW-1:0] prev;
      repeat (4) @(posedge clk);
      #2;
      chk("R1 reset rd_valid", rd_valid, 0);
      chk("R1 reset err_flag", err_flag, 0);
      chk("R1 reset scrub_addr", scrub_addr, 0);
      chk("R1 reset scrub_passes", scrub_passes, 0);
      rst_n = 1;
      for (int a = 0; a < DEPTH; a++) step(1, 1, a, pat(a));

      rd_check(5, pat(5), 0, 3'b000, "R2 read back");
      rd_check(255, pat(255), 0, 3'b000, "R2 read top word");

      stepi(1, 0, 0, '0, 1, 10, 16'hFFFF);
      rd_check(10, pat(10), 1, 3'b010, "R3 copy1 fully flipped");
      rd_check(10, pat(10), 1, 3'b010, "R5 user read leaves fault");

      stepi(1, 0, 0, '0, 0, 20, 16'h00F0);
      stepi(1, 0, 0, '0, 2, 20, 16'h0F00);
      rd_check(20, pat(20), 1, 3'b101, "R3 split two-copy fault");

      stepi(1, 0, 0, '0, 2, 30, 16'h0001);
      rd_check(30, pat(30), 1, 3'b100, "R10 only copy2 touched");

      p0 = int'(scrub_addr);
      for (int i = 0; i < 40; i++) step(1, 0, 100 + i, '0);
      chk("R4 pointer frozen under user traffic", scrub_addr, p0);

      saw_wrap = 0;
      prev = scrub_addr;
      for (int i = 0; i < 700; i++) begin
         step(0, 0, 0, '0);
         if (prev == AW'(DEPTH - 1) && scrub_addr == '0) saw_wrap = 1;
         prev = scrub_addr;
      end
      chk("R6 pointer wrapped to 0", saw_wrap, 1);
      chk("R7 one pass counted", scrub_passes, 1);
      rd_check(10, pat(10), 0, 3'b000, "R8 repaired word 10");
      rd_check(20, pat(20), 0, 3'b000, "R8 repaired word 20");
      rd_check(30, pat(30), 0, 3'b000, "R8 repaired word 30");

      for (int i = 0; i < 10 && (m_infl || m_pend); i++) step(0, 0, 0, '0);
      p0 = int'(scrub_addr);
      for (int i = 0; i < 20; i++) step(0, 0, 0, '0);
      chk("R8 clean words take two idle cycles", scrub_addr, (p0 + 10) % DEPTH);

      idle_until_ptr(40);
      stepi(1, 0, 0, '0, 0, 40, 16'h1234);
      step(0, 0, 0, '0);
      step(1, 1, 40, 16'hBEEF);
      repeat (4) step(0, 0, 0, '0);
      rd_check(40, 16'hBEEF, 0, 3'b000, "R9 same-cycle user write wins");

      idle_until_ptr(60);
      stepi(1, 0, 0, '0, 2, 60, 16'h00FF);
      step(0, 0, 0, '0);
      step(1, 0, 0, '0);
      step(1, 1, 60, 16'hCAFE);
      repeat (6) step(0, 0, 0, '0);
      rd_check(60, 16'hCAFE, 0, 3'b000, "R9 pending repair cancelled");

      step(0, 0, 0, '0);
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog expired before the end of the scenarios");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

endmodule